// File: doc/BRIEF.md
# Vector Strided Address Generator

This block turns one vector load or store request into a stream of element byte addresses. A request gives a base address, an element size, and optional operands: a length limit, an element-granular stride, and an extra scalar increment. Two flags shape the walk. Strip-mining spreads the instruction over four consecutive vector registers. Quad mode splits each register into four quarters, and each quarter gets its own base.

The addresses leave one per cycle on a valid/ready stream. After the last handshake the block raises a one-cycle done pulse. With the pulse it gives the post-incremented base address for write-back to the scalar register, and a per-lane keep mask that tells a load which destination lanes to fill with zero.

A separate combinational port answers the vector-length query. It returns the elements a register holds, four times that with strip-mining, and clamps the result by up to two scalar operands.

Top module: `vec_stride_agu`

## Requirements
- R1: The request address is ANDed with the `MEM_MASK` parameter before any use. The first element address, and the write-back value for an empty request, use the masked value.
- R2: Element size code `req_esize` is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Elements per register = `VREG_BYTES` / size. The element count is elements per register × registers covered, where registers covered is 4 with `req_strip` and 1 without. With `req_has_len`, the count is the smaller of that value and `req_len`. Exactly that many addresses are issued.
- R3: Outside quad mode, element i of a register is at running base + i × size. The running base advances by stride × size after each register. The stride is `req_stride` with `req_has_stride`, and elements per register otherwise.
- R4: In quad mode (`req_quad`), each register is walked as four quarters of elements-per-register/4 elements. Each quarter is contiguous from the running base, and the base advances by stride × size after every quarter.
- R5: The write-back address is the masked address plus the increment given by the first rule that matches:
  - length and stride both present: `VREG_BYTES`.
  - neither length nor stride present, and `req_has_xop` low: `VREG_BYTES` × registers covered.
  - length only: count × size.
  - stride only: stride × size × registers covered, and ×4 again in quad mode.
  - otherwise: `req_xop` × size.
- R6: When the count is zero, no address is issued. The done pulse follows in the cycle after acceptance, and `done_addr` is the masked address unchanged.
- R7: While `el_valid` is high and `el_ready` is low, `el_valid` stays high and `el_addr` holds.
- R8: `done` is high for exactly one cycle, one cycle after the final handshake. `req_ready` is high only in the idle state: low from the cycle after acceptance through the done cycle, and high again the cycle after done.
- R9: `load_keep` bit j is 1 exactly when j < count. It is valid from the cycle after acceptance.
- R10: `vl_out` is elements per register for `vl_esize` (same coding as R2), ×4 when `vl_strip` is set. It is then reduced to `vl_a` when `vl_use_a` is set and `vl_a` is smaller, and likewise for `vl_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | ADDR_W | Base address before masking |
| req_esize | input | 2 | Element size code |
| req_strip | input | 1 | Cover four registers |
| req_quad | input | 1 | Quarter-register walk |
| req_has_len | input | 1 | Length operand present |
| req_has_stride | input | 1 | Stride operand present |
| req_has_xop | input | 1 | Extra scalar increment present |
| req_len | input | ADDR_W | Length operand in elements |
| req_stride | input | ADDR_W | Stride operand in elements |
| req_xop | input | ADDR_W | Scalar increment in elements |
| el_valid | output | 1 | Element address valid |
| el_ready | input | 1 | Element address taken |
| el_addr | output | ADDR_W | Element byte address |
| done | output | 1 | One-cycle end pulse |
| done_addr | output | ADDR_W | Post-incremented address |
| load_keep | output | 4*VREG_BYTES | Lane keep mask, zero-fill where 0 |
| vl_esize | input | 2 | Query element size code |
| vl_strip | input | 1 | Query strip-mine flag |
| vl_use_a | input | 1 | Clamp by vl_a |
| vl_a | input | ADDR_W | First clamp operand |
| vl_use_b | input | 1 | Clamp by vl_b |
| vl_b | input | ADDR_W | Second clamp operand |
| vl_out | output | ADDR_W | Vector length result |

## Verification
An accepted request shows its first address on `el_addr` one cycle after the accepting edge, and each handshake moves the stream on by one edge. `done`, `done_addr` and the final keep mask follow one cycle after the last handshake, or one cycle after acceptance when the count is zero. The bench samples on the falling edge and counts a handshake only where it saw valid and ready together. It checks the done values at the first falling edge on which `done` is seen, and checks at the next edge that the pulse has gone. The vector-length answer is combinational, so it is checked a fraction of a cycle after its inputs change.

// File: rtl/vec_agu_pkg.sv
package vec_agu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } agu_state_e;

    // size code to log2 of the element byte count; code 3 behaves as 4 bytes
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/vec_agu_count.sv
module vec_agu_count
    import vec_agu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int VREG_BYTES = 16,
    parameter int CNT_W      = 7
) (
    input  logic [1:0]        esize,
    input  logic              strip,
    input  logic              quad,
    input  logic              has_len,
    input  logic [ADDR_W-1:0] len,
    input  logic              has_stride,
    input  logic [ADDR_W-1:0] stride,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  seg_len,
    output logic [ADDR_W-1:0] stride_bytes
);
    logic [1:0]        sh;
    logic [CNT_W-1:0]  per_reg;
    logic [CNT_W-1:0]  full;
    logic [ADDR_W-1:0] stride_el;

    always_comb begin
        sh        = size_shift(esize);
        per_reg   = CNT_W'(VREG_BYTES) >> sh;
        full      = strip ? (per_reg << 2) : per_reg;
        count     = (has_len && (len < ADDR_W'(full))) ? CNT_W'(len) : full;
        seg_len   = quad ? (per_reg >> 2) : per_reg;
        stride_el = has_stride ? stride : ADDR_W'(per_reg);
        stride_bytes = stride_el << sh;
    end
endmodule

// File: rtl/vec_agu_wb.sv
module vec_agu_wb
    import vec_agu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int VREG_BYTES = 16,
    parameter int CNT_W      = 7
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        esize,
    input  logic              strip,
    input  logic              quad,
    input  logic              has_len,
    input  logic              has_stride,
    input  logic              has_xop,
    input  logic [ADDR_W-1:0] stride,
    input  logic [ADDR_W-1:0] xop,
    output logic [ADDR_W-1:0] wb
);
    logic [1:0]        sh;
    logic [ADDR_W-1:0] regs_bytes;
    logic [ADDR_W-1:0] stride_step;

    always_comb begin
        sh          = size_shift(esize);
        regs_bytes  = strip ? ADDR_W'(4 * VREG_BYTES) : ADDR_W'(VREG_BYTES);
        stride_step = (stride << sh) << (strip ? 2 : 0);
        if (quad) stride_step = stride_step << 2;
        if (count == '0)                          wb = base;
        else if (has_len && has_stride)           wb = base + ADDR_W'(VREG_BYTES);
        else if (!has_len && !has_stride && !has_xop) wb = base + regs_bytes;
        else if (has_len)                         wb = base + (ADDR_W'(count) << sh);
        else if (has_stride)                      wb = base + stride_step;
        else                                      wb = base + (xop << sh);
    end
endmodule

// File: rtl/vec_agu_vlen.sv
module vec_agu_vlen
    import vec_agu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int VREG_BYTES = 16
) (
    input  logic [1:0]        esize,
    input  logic              strip,
    input  logic              use_a,
    input  logic [ADDR_W-1:0] a,
    input  logic              use_b,
    input  logic [ADDR_W-1:0] b,
    output logic [ADDR_W-1:0] vl
);
    logic [ADDR_W-1:0] top_len;
    logic [ADDR_W-1:0] after_a;

    always_comb begin
        top_len = ADDR_W'(VREG_BYTES) >> size_shift(esize);
        if (strip) top_len = top_len << 2;
        after_a = (use_a && (a < top_len)) ? a : top_len;
        vl      = (use_b && (b < after_a)) ? b : after_a;
    end
endmodule

// File: rtl/vec_stride_agu.sv
module vec_stride_agu
    import vec_agu_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                VREG_BYTES = 16,
    parameter logic [ADDR_W-1:0] MEM_MASK   = 32'h003F_FFFF,
    localparam int               MAX_EL     = 4 * VREG_BYTES,
    localparam int               CNT_W      = $clog2(MAX_EL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_esize,
    input  logic              req_strip,
    input  logic              req_quad,
    input  logic              req_has_len,
    input  logic              req_has_stride,
    input  logic              req_has_xop,
    input  logic [ADDR_W-1:0] req_len,
    input  logic [ADDR_W-1:0] req_stride,
    input  logic [ADDR_W-1:0] req_xop,
    output logic              el_valid,
    input  logic              el_ready,
    output logic [ADDR_W-1:0] el_addr,
    output logic              done,
    output logic [ADDR_W-1:0] done_addr,
    output logic [MAX_EL-1:0] load_keep,
    input  logic [1:0]        vl_esize,
    input  logic              vl_strip,
    input  logic              vl_use_a,
    input  logic [ADDR_W-1:0] vl_a,
    input  logic              vl_use_b,
    input  logic [ADDR_W-1:0] vl_b,
    output logic [ADDR_W-1:0] vl_out
);
    typedef struct packed {
        agu_state_e        st;
        logic [ADDR_W-1:0] seg_base;
        logic [ADDR_W-1:0] run;
        logic [ADDR_W-1:0] stride_b;
        logic [ADDR_W-1:0] wb;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  seg_len;
        logic [CNT_W-1:0]  inseg;
        logic [CNT_W-1:0]  issued;
        logic [1:0]        sh;
        logic [MAX_EL-1:0] keep;
    } agu_regs_t;

    agu_regs_t         r_d, r_q;
    logic [ADDR_W-1:0] masked;
    logic [CNT_W-1:0]  cnt_w, seg_w;
    logic [ADDR_W-1:0] strb_w, wb_w;
    logic              accept;

    assign masked = req_addr & MEM_MASK;

    vec_agu_count #(.ADDR_W(ADDR_W), .VREG_BYTES(VREG_BYTES), .CNT_W(CNT_W)) i_count (
        .esize(req_esize), .strip(req_strip), .quad(req_quad),
        .has_len(req_has_len), .len(req_len),
        .has_stride(req_has_stride), .stride(req_stride),
        .count(cnt_w), .seg_len(seg_w), .stride_bytes(strb_w)
    );

    vec_agu_wb #(.ADDR_W(ADDR_W), .VREG_BYTES(VREG_BYTES), .CNT_W(CNT_W)) i_wb (
        .base(masked), .count(cnt_w), .esize(req_esize), .strip(req_strip),
        .quad(req_quad), .has_len(req_has_len), .has_stride(req_has_stride),
        .has_xop(req_has_xop), .stride(req_stride), .xop(req_xop), .wb(wb_w)
    );

    vec_agu_vlen #(.ADDR_W(ADDR_W), .VREG_BYTES(VREG_BYTES)) i_vlen (
        .esize(vl_esize), .strip(vl_strip), .use_a(vl_use_a), .a(vl_a),
        .use_b(vl_use_b), .b(vl_b), .vl(vl_out)
    );

    assign req_ready = (r_q.st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign el_valid  = (r_q.st == ST_RUN);
    assign el_addr   = r_q.run;
    assign done      = (r_q.st == ST_FIN);
    assign done_addr = r_q.wb;
    assign load_keep = r_q.keep;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st       = (cnt_w == '0) ? ST_FIN : ST_RUN;
                    r_d.seg_base = masked;
                    r_d.run      = masked;
                    r_d.stride_b = strb_w;
                    r_d.wb       = wb_w;
                    r_d.count    = cnt_w;
                    r_d.seg_len  = seg_w;
                    r_d.inseg    = '0;
                    r_d.issued   = '0;
                    r_d.sh       = size_shift(req_esize);
                    for (int j = 0; j < MAX_EL; j++) begin
                        r_d.keep[j] = (32'(j) < 32'(cnt_w));
                    end
                end
            end
            ST_RUN: begin
                if (el_ready) begin
                    r_d.issued = r_q.issued + 1'b1;
                    if (r_q.issued + 1'b1 == r_q.count) begin
                        r_d.st = ST_FIN;
                    end else if (r_q.inseg + 1'b1 == r_q.seg_len) begin
                        r_d.inseg    = '0;
                        r_d.seg_base = r_q.seg_base + r_q.stride_b;
                        r_d.run      = r_q.seg_base + r_q.stride_b;
                    end else begin
                        r_d.inseg = r_q.inseg + 1'b1;
                        r_d.run   = r_q.run + (ADDR_W'(1) << r_q.sh);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid && !el_ready |=> el_valid && $stable(el_addr));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (cnt_w == '0) |=> done && !el_valid);

    // R2
    issue_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |-> r_q.issued < r_q.count);
endmodule

// File: tb/test_vec_stride_agu.sv
module test_vec_stride_agu;
    localparam int AW = 32;
    localparam int VB = 16;
    localparam logic [31:0] MASK = 32'h003F_FFFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_ready;
    logic [31:0] req_addr = 0, req_len = 0, req_stride = 0, req_xop = 0;
    logic [1:0] req_esize = 0;
    logic req_strip = 0, req_quad = 0, req_has_len = 0, req_has_stride = 0, req_has_xop = 0;
    logic el_valid, el_ready = 0, done;
    logic [31:0] el_addr, done_addr, vl_out;
    logic [63:0] load_keep;
    logic [1:0] vl_esize = 0;
    logic vl_strip = 0, vl_use_a = 0, vl_use_b = 0;
    logic [31:0] vl_a = 0, vl_b = 0;

    int checks = 0, fails = 0, cyc = 0, rctr = 0;
    logic [31:0] exp_a [64];

    always #5 clk = ~clk;

    vec_stride_agu i_vec_stride_agu (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_esize, .req_strip,
        .req_quad, .req_has_len, .req_has_stride, .req_has_xop, .req_len,
        .req_stride, .req_xop, .el_valid, .el_ready, .el_addr, .done, .done_addr,
        .load_keep, .vl_esize, .vl_strip, .vl_use_a, .vl_a, .vl_use_b, .vl_b, .vl_out
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic run_case(input logic [31:0] addr, input int es, input bit st, input bit qd,
                            input bit hl, input bit hs, input bit hx,
                            input logic [31:0] len, input logic [31:0] strd, input logic [31:0] xo);
        int esz, epr, nregs, full, cnt, seg, segs, n;
        logic [31:0] m, base, sel, wb;
        bit got;
        esz = 1 << es; epr = VB / esz; nregs = st ? 4 : 1; full = epr * nregs;
        cnt = (hl && len < full) ? int'(len) : full;
        seg = qd ? epr / 4 : epr;
        segs = nregs * (qd ? 4 : 1);
        sel = hs ? strd : epr;
        m = addr & MASK;
        base = m; n = 0;
        for (int s = 0; s < segs; s++) begin
            for (int j = 0; j < seg; j++) begin
                if (n < cnt) begin exp_a[n] = base + j * esz; n++; end
            end
            base = base + sel * esz;
        end
        if (cnt == 0) wb = m;
        else if (hl && hs) wb = m + VB;
        else if (!hl && !hs && !hx) wb = m + VB * nregs;
        else if (hl) wb = m + cnt * esz;
        else if (hs) wb = m + strd * esz * nregs * (qd ? 4 : 1);
        else wb = m + xo * esz;

        while (!req_ready) @(negedge clk);
        req_addr = addr; req_esize = 2'(es); req_strip = st; req_quad = qd;
        req_has_len = hl; req_has_stride = hs; req_has_xop = hx;
        req_len = len; req_stride = strd; req_xop = xo; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R8 busy after accept", req_ready, 0);
        n = 0; got = 0;
        for (int k = 0; k < 600 && !got; k++) begin
            if (done) begin
                got = 1;
                chk(n == cnt, "R2 element count", n, cnt);
                // R5 R6 R1: write-back address
                chk(done_addr == wb, "R5 write-back", done_addr, wb);
                for (int j = 0; j < 64; j++)
                    chk(load_keep[j] == (j < cnt), "R9 keep mask", load_keep[j], (j < cnt));
                @(negedge clk);
                chk(!done && req_ready, "R8 single done pulse", done, 0);
            end else begin
                rctr++;
                el_ready = (rctr % 4) != 1;
                if (el_valid && el_ready) begin
                    if (n < cnt) chk(el_addr == exp_a[n], qd ? "R4 quad address" : "R3 address", el_addr, exp_a[n]);
                    else chk(0, "R2 extra element", n, cnt);
                    n++;
                end else if (el_valid) begin
                    logic [31:0] held;
                    held = el_addr;
                    @(negedge clk);
                    // R7: stalled address holds
                    chk(el_valid && el_addr == held, "R7 hold", el_addr, held);
                    continue;
                end
                @(negedge clk);
            end
        end
        if (!got) chk(0, "R8 done missing", 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1 && el_valid == 0 && done == 0, "R8 reset state", {req_ready, el_valid, done}, 3'b100);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && el_valid == 0 && done == 0, "R8 idle after reset", {req_ready, el_valid, done}, 3'b100);
        for (int es = 0; es < 3; es++)
            for (int st = 0; st < 2; st++)
                for (int qd = 0; qd < 2; qd++)
                    for (int fl = 0; fl < 8; fl++)
                        for (int v = 0; v < 3; v++) begin
                            logic [31:0] lv, sv;
                            lv = (v == 0) ? 0 : (v == 1) ? 5 : 200;
                            sv = (v == 2) ? 20 : 3;
                            if (!fl[0] && v == 0) continue;
                            // R1: high bits outside the window must be stripped
                            run_case(32'hFF00_1000 + 32'(v * 64), es, st[0], qd[0],
                                     fl[0], fl[1], fl[2], lv, sv, 32'd7 + 32'(v));
                        end
        for (int es = 0; es < 3; es++)
            for (int st = 0; st < 2; st++)
                for (int ua = 0; ua < 2; ua++)
                    for (int ub = 0; ub < 2; ub++)
                        for (int v = 0; v < 2; v++) begin
                            int e;
                            @(negedge clk);
                            vl_esize = 2'(es); vl_strip = st[0]; vl_use_a = ua[0]; vl_use_b = ub[0];
                            vl_a = v ? 32'd1000 : 32'd3; vl_b = v ? 32'd0 : 32'd7;
                            e = (VB >> es) * (st ? 4 : 1);
                            if (ua && vl_a < e) e = vl_a;
                            if (ub && vl_b < e) e = vl_b;
                            #1;
                            chk(vl_out == e, "R10 vector length", vl_out, e);
                        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule